// File: doc/BRIEF.md
# Two-Phase Bit-Addressable Static Memory

This block is a cycle-level model of a 128-cell, one-bit-wide static memory laid out as 16 rows by 8 columns. A 7-bit address picks one cell: the low four bits pick a row and the upper three bits pick a column through a one-hot column select that steers that column's bitline pair. Each column has its own precharge unit. The data path is one bit in and one bit out, with separate read and write strobes.

The block runs from one system clock `clk`, on which two phase qualifiers are sampled. `pre_ph` marks the precharge phase and `acc_ph` marks the access phase. A legal cycle raises `pre_ph`, drops it, and then raises `acc_ph` while the address, data and strobes are presented. The operation is latched on the first clock edge of the access phase and completes on the edge where `acc_ph` is first sampled low. At that edge a write is committed to the cell, or a read is resolved by the sense stage. The bitline pairs are then discharged and must be precharged again before the next access.

A phase controller moves through five named states:
- COLD: after reset or after a phase overlap; the bitlines are not precharged.
- PRE: precharge phase sampled high.
- ARMED: precharged and waiting for an access.
- ACCESS: wordline and column select driven.
- SPENT: an access has ended and no new precharge has happened yet.

Transitions:
- Any state goes to COLD when both phases are sampled high.
- Any state goes to PRE when only `pre_ph` is sampled high.
- COLD, PRE, ARMED and SPENT go to ACCESS when only `acc_ph` is sampled high. ACCESS stays in ACCESS while `acc_ph` is high.
- With both phases low, PRE and ARMED go to ARMED, ACCESS goes to SPENT, and COLD and SPENT stay where they are.

Top module: `sram2ph_macro`

## Requirements
- R1: After reset `dout`, `bl_ready`, `err_conflict` and `err_proto` are 0, no row or column line is active, and every cell reads back as 0.
- R2: Address bits [3:0] select the row and bits [6:4] select the column. Each of the 128 addresses holds its own bit, and writing one cell leaves all others unchanged.
- R3: One clock edge after `pre_ph` is sampled high with `acc_ph` low, `bl_ready` is 1 (all 8 column precharge units charged). The edge that ends an access phase clears it.
- R4: `row_line` has at most one bit set. It equals the one-hot row of the latched address only during an accepted access phase (precharged and at least one strobe). `col_line` behaves the same way for the column. Both are 0 otherwise.
- R5: A write stores the `din` value presented on the first edge of the access phase. It is committed on the edge where `acc_ph` is first sampled low.
- R6: `dout` changes only at the end of an accepted read, where it takes the addressed cell's value. It keeps that value through later precharge phases, write accesses and rejected accesses until the next read.
- R7: If read and write strobes are both high at access start, the write is performed, `dout` is unchanged, and `err_conflict` is 1 until the next access start. At every other access start it is loaded with 0.
- R8: An access started with a strobe but without a preceding precharge phase is rejected. `err_proto` becomes 1, no row or column line rises, no cell is written and `dout` holds. An accepted access start loads `err_proto` with 0.
- R9: If both phases are sampled high together, `err_proto` becomes 1, the precharge is lost (`bl_ready` is 0), and any access in progress is abandoned without commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which both phases are sampled |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_ph | input | 1 | Precharge phase qualifier |
| acc_ph | input | 1 | Access phase qualifier |
| addr | input | 7 | Cell address: [3:0] row, [6:4] column |
| din | input | 1 | Write data bit |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| dout | output | 1 | Sensed read data, held between reads |
| bl_ready | output | 1 | All bitline pairs precharged |
| row_line | output | 16 | One-hot wordlines |
| col_line | output | 8 | One-hot column select |
| err_conflict | output | 1 | Both strobes seen at last access start |
| err_proto | output | 1 | Access without precharge, or phase overlap |

## Verification
The results come due at different edges:
- `bl_ready` is due one edge after the precharge phase is sampled.
- `row_line`, `col_line`, `err_conflict` and `err_proto` are due one edge after the access phase is first sampled high.
- `dout`, the cell contents and the drop of `bl_ready` are due on the edge that samples `acc_ph` low.

The bench drives inputs on falling edges and samples on the falling edge right after each of those rising edges. It checks the wordlines and column lines in the middle of the access phase, and checks the data and flags just after the access ends. Random reads, writes and conflicts are compared against a 128-entry reference array. Directed cases cover the rejected first access after reset and a phase overlap.

// File: rtl/sram2ph_pkg.sv
package sram2ph_pkg;
    typedef enum logic [2:0] {
        PH_COLD   = 3'd0,
        PH_PRE    = 3'd1,
        PH_ARMED  = 3'd2,
        PH_ACCESS = 3'd3,
        PH_SPENT  = 3'd4
    } phase_e;
endpackage

// File: rtl/sram2ph_row_decoder.sv
module sram2ph_row_decoder #(
    parameter int ROW_BITS = 4
) (
    input  logic [ROW_BITS-1:0]    row,
    input  logic                   en,
    output logic [(1<<ROW_BITS)-1:0] wl
);
    localparam int LO_BITS = ROW_BITS / 2;
    localparam int HI_BITS = ROW_BITS - LO_BITS;
    localparam int LO_N    = 1 << LO_BITS;
    localparam int HI_N    = 1 << HI_BITS;
    localparam int ROWS    = 1 << ROW_BITS;

    logic [LO_N-1:0] pre_lo;
    logic [HI_N-1:0] pre_hi;

    // predecode stage: two small one-hot groups
    generate
        for (genvar i = 0; i < LO_N; i++) begin : g_lo
            assign pre_lo[i] = (row[LO_BITS-1:0] == LO_BITS'(i));
        end
        for (genvar j = 0; j < HI_N; j++) begin : g_hi
            assign pre_hi[j] = (row[ROW_BITS-1:LO_BITS] == HI_BITS'(j));
        end
        // output stage: gate each pair with the access enable
        for (genvar k = 0; k < ROWS; k++) begin : g_wl
            assign wl[k] = en & pre_lo[k % LO_N] & pre_hi[k / LO_N];
        end
    endgenerate
endmodule

// File: rtl/sram2ph_col_select.sv
module sram2ph_col_select #(
    parameter int COL_BITS = 3
) (
    input  logic [COL_BITS-1:0]      col,
    input  logic                     en,
    input  logic                     drive_en,
    input  logic                     din,
    input  logic [(1<<COL_BITS)-1:0] row_data,
    output logic [(1<<COL_BITS)-1:0] col_line,
    output logic                     bl_t,
    output logic                     bl_c
);
    localparam int COLS = 1 << COL_BITS;

    logic sel_bit;

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign col_line[c] = en & (col == COL_BITS'(c));
        end
    endgenerate

    // pass switches: only the selected column reaches the shared pair
    assign sel_bit = |(row_data & col_line);

    // write driver pulls exactly one line low; otherwise the cell does
    always_comb begin
        if (drive_en) begin
            bl_t = din;
            bl_c = ~din;
        end else if (|col_line) begin
            bl_t = sel_bit;
            bl_c = ~sel_bit;
        end else begin
            bl_t = 1'b1;
            bl_c = 1'b1;
        end
    end
endmodule

// File: rtl/sram2ph_precharge.sv
module sram2ph_precharge (
    input  logic clk,
    input  logic rst_n,
    input  logic charge,
    input  logic drain,
    output logic level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      level <= 1'b0;
        else if (charge) level <= 1'b1;
        else if (drain)  level <= 1'b0;
    end
endmodule

// File: rtl/sram2ph_sense.sv
module sram2ph_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic bl_t,
    input  logic bl_c,
    output logic q
);
    // isolated unless fired; resolves only a differential pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    q <= 1'b0;
        else if (fire && (bl_t ^ bl_c)) q <= bl_t;
    end
endmodule

// File: rtl/sram2ph_macro.sv
module sram2ph_macro #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pre_ph,
    input  logic                       acc_ph,
    input  logic [ROW_BITS+COL_BITS-1:0] addr,
    input  logic                       din,
    input  logic                       rd_stb,
    input  logic                       wr_stb,
    output logic                       dout,
    output logic                       bl_ready,
    output logic [(1<<ROW_BITS)-1:0]   row_line,
    output logic [(1<<COL_BITS)-1:0]   col_line,
    output logic                       err_conflict,
    output logic                       err_proto
);
    import sram2ph_pkg::*;

    localparam int ROWS = 1 << ROW_BITS;
    localparam int COLS = 1 << COL_BITS;

    phase_e state, state_nx;

    logic overlap, charge, acc_start, acc_end, wl_en, wr_fire, rd_fire;
    logic [COLS-1:0] pc_level;

    logic [ROW_BITS-1:0] op_row;
    logic [COL_BITS-1:0] op_col;
    logic                op_din, op_rd, op_wr, op_valid;

    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] row_data;
    logic            bl_t, bl_c;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_COLD;
        else        state <= state_nx;
    end

    // next state and decoded events
    always_comb begin
        overlap   = pre_ph & acc_ph;
        charge    = pre_ph & ~acc_ph;
        acc_start = 1'b0;
        acc_end   = 1'b0;
        wl_en     = 1'b0;
        state_nx  = state;
        unique case (state)
            PH_COLD, PH_SPENT: begin
                if (overlap)     state_nx = PH_COLD;
                else if (pre_ph) state_nx = PH_PRE;
                else if (acc_ph) begin
                    state_nx  = PH_ACCESS;
                    acc_start = 1'b1;
                end
            end
            PH_PRE, PH_ARMED: begin
                if (overlap)     state_nx = PH_COLD;
                else if (pre_ph) state_nx = PH_PRE;
                else if (acc_ph) begin
                    state_nx  = PH_ACCESS;
                    acc_start = 1'b1;
                end else         state_nx = PH_ARMED;
            end
            PH_ACCESS: begin
                wl_en = op_valid;
                if (overlap)     state_nx = PH_COLD;
                else if (acc_ph) state_nx = PH_ACCESS;
                else begin
                    acc_end  = 1'b1;
                    state_nx = pre_ph ? PH_PRE : PH_SPENT;
                end
            end
            default: state_nx = PH_COLD;
        endcase
        wr_fire = acc_end & op_valid & op_wr;
        rd_fire = acc_end & op_valid & op_rd & ~op_wr;
    end

    // operation latch at access start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_row   <= '0;
            op_col   <= '0;
            op_din   <= 1'b0;
            op_rd    <= 1'b0;
            op_wr    <= 1'b0;
            op_valid <= 1'b0;
        end else if (acc_start) begin
            op_row   <= addr[ROW_BITS-1:0];
            op_col   <= addr[ROW_BITS+COL_BITS-1:ROW_BITS];
            op_din   <= din;
            op_rd    <= rd_stb;
            op_wr    <= wr_stb;
            op_valid <= bl_ready & (rd_stb | wr_stb);
        end
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_conflict <= 1'b0;
            err_proto    <= 1'b0;
        end else if (overlap) begin
            err_proto    <= 1'b1;
        end else if (acc_start) begin
            err_conflict <= rd_stb & wr_stb;
            err_proto    <= ~bl_ready & (rd_stb | wr_stb);
        end
    end

    // per-column precharge units
    generate
        for (genvar c = 0; c < COLS; c++) begin : g_pc
            sram2ph_precharge u_pc (
                .clk    (clk),
                .rst_n  (rst_n),
                .charge (charge),
                .drain  (acc_end | overlap),
                .level  (pc_level[c])
            );
        end
    endgenerate
    assign bl_ready = &pc_level;

    sram2ph_row_decoder #(.ROW_BITS(ROW_BITS)) u_rowdec (
        .row (op_row),
        .en  (wl_en),
        .wl  (row_line)
    );

    sram2ph_col_select #(.COL_BITS(COL_BITS)) u_colsel (
        .col      (op_col),
        .en       (wl_en),
        .drive_en (wl_en & op_wr),
        .din      (op_din),
        .row_data (row_data),
        .col_line (col_line),
        .bl_t     (bl_t),
        .bl_c     (bl_c)
    );

    // cell array: read the active wordline, write through the pair
    always_comb begin
        row_data = '0;
        for (int r = 0; r < ROWS; r++)
            if (row_line[r]) row_data = row_data | cells[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) cells[r] <= '0;
        end else if (wr_fire && (bl_t ^ bl_c)) begin
            for (int r = 0; r < ROWS; r++)
                if (row_line[r])
                    cells[r] <= (cells[r] & ~col_line) | (col_line & {COLS{bl_t}});
        end
    end

    sram2ph_sense u_sense (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (rd_fire),
        .bl_t  (bl_t),
        .bl_c  (bl_c),
        .q     (dout)
    );
endmodule

// File: rtl/sram2ph_checker.sv
module sram2ph_checker #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pre_ph,
    input logic                     acc_ph,
    input logic                     rd_stb,
    input logic                     wr_stb,
    input logic                     dout,
    input logic                     bl_ready,
    input logic [(1<<ROW_BITS)-1:0] row_line,
    input logic [(1<<COL_BITS)-1:0] col_line,
    input logic                     err_conflict,
    input logic                     err_proto
);
    assert_row_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_line));

    assert_col_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_line) && ((|col_line) == (|row_line)));

    assert_wl_in_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|row_line) |-> ($past(acc_ph) && bl_ready));

    assert_precharge_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_ph && !acc_ph) |=> bl_ready);

    assert_dout_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout != $past(dout)) |-> ($past(|row_line) && !$past(acc_ph)));

    assert_conflict_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_conflict) |-> $past(rd_stb && wr_stb));

    assert_reject_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_proto) |-> $stable(dout));
endmodule

bind sram2ph_macro sram2ph_checker #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pre_ph       (pre_ph),
    .acc_ph       (acc_ph),
    .rd_stb       (rd_stb),
    .wr_stb       (wr_stb),
    .dout         (dout),
    .bl_ready     (bl_ready),
    .row_line     (row_line),
    .col_line     (col_line),
    .err_conflict (err_conflict),
    .err_proto    (err_proto)
);

// File: tb/sim_sram2ph_macro.sv
module sim_sram2ph_macro;
    localparam int CELLS = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_ph = 1'b0, acc_ph = 1'b0;
    logic [6:0]  addr = '0;
    logic        din = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic        dout, bl_ready, err_conflict, err_proto;
    logic [15:0] row_line;
    logic [7:0]  col_line;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  ref_mem [CELLS];
    bit  exp_dout = 1'b0;
    bit  primed   = 1'b0;

    always #2.5 clk = ~clk;

    sram2ph_macro u0 (
        .clk(clk), .rst_n(rst_n), .pre_ph(pre_ph), .acc_ph(acc_ph),
        .addr(addr), .din(din), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .dout(dout), .bl_ready(bl_ready), .row_line(row_line),
        .col_line(col_line), .err_conflict(err_conflict), .err_proto(err_proto)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rows(input logic [6:0] a, input bit v);
        return v ? (16'h1 << a[3:0]) : 16'h0;
    endfunction

    function automatic logic [7:0] exp_cols(input logic [6:0] a, input bit v);
        return v ? (8'h1 << a[6:4]) : 8'h0;
    endfunction

    task automatic precharge();
        @(negedge clk);
        pre_ph = 1'b1;
        @(negedge clk);
        pre_ph = 1'b0;
        primed = 1'b1;
        check(bl_ready == 1'b1, "R3 ready after precharge", bl_ready, 1);
    endtask

    task automatic access(input logic [6:0] a, input bit d, input bit rd, input bit wr);
        bit v;
        v = primed && (rd || wr);
        @(negedge clk);
        acc_ph = 1'b1; addr = a; din = d; rd_stb = rd; wr_stb = wr;
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0; din = ~d;
        check(row_line == exp_rows(a, v), "R4 row_line", row_line, exp_rows(a, v));
        check(col_line == exp_cols(a, v), "R4 col_line", col_line, exp_cols(a, v));
        @(negedge clk);
        acc_ph = 1'b0;
        @(negedge clk);
        if (v && wr) ref_mem[a] = d;
        else if (v && rd) exp_dout = ref_mem[a];
        primed = 1'b0;
        check(dout == exp_dout, "R6 dout", dout, exp_dout);
        check(err_conflict == (rd && wr), "R7 err_conflict", err_conflict, rd && wr);
        check(err_proto == (!v && (rd || wr)), "R8 err_proto", err_proto, !v && (rd || wr));
        check(bl_ready == 1'b0, "R3 ready cleared", bl_ready, 0);
        check(row_line == 16'h0, "R4 row_line idle", row_line, 0);
    endtask

    task automatic op(input logic [6:0] a, input bit d, input bit rd, input bit wr);
        precharge();
        access(a, d, rd, wr);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < CELLS; i++) ref_mem[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(dout == 1'b0, "R1 dout", dout, 0);
        check(bl_ready == 1'b0, "R1 bl_ready", bl_ready, 0);
        check(err_conflict == 1'b0 && err_proto == 1'b0, "R1 flags",
              {err_conflict, err_proto}, 0);
        check(row_line == 16'h0 && col_line == 8'h0, "R1 lines", row_line, 0);
        rst_n = 1'b1;

        // R8: first access after reset without precharge is rejected
        access(7'd5, 1'b1, 1'b0, 1'b1);
        op(7'd5, 1'b0, 1'b1, 1'b0);
        check(dout == 1'b0, "R8 rejected write left cell", dout, 0);

        // R2 / R5: corners and neighbours
        op(7'd0, 1'b1, 1'b0, 1'b1);
        op(7'd127, 1'b1, 1'b0, 1'b1);
        op(7'd1, 1'b0, 1'b1, 1'b0);
        check(dout == 1'b0, "R2 neighbour untouched", dout, 0);
        op(7'd0, 1'b0, 1'b1, 1'b0);
        check(dout == 1'b1, "R5 stored din", dout, 1);
        op(7'd127, 1'b0, 1'b1, 1'b0);
        check(dout == 1'b1, "R2 top cell", dout, 1);

        // R6: dout holds across writes and idle precharge
        op(7'd16, 1'b0, 1'b0, 1'b1);
        precharge();
        check(dout == 1'b1, "R6 hold", dout, 1);
        access(7'd16, 1'b0, 1'b1, 1'b0);

        // R7: conflict, write wins
        op(7'd33, 1'b1, 1'b1, 1'b1);
        op(7'd33, 1'b0, 1'b1, 1'b0);
        check(dout == 1'b1, "R7 write won", dout, 1);

        // R8: access after access without a new precharge
        access(7'd33, 1'b0, 1'b0, 1'b1);
        op(7'd33, 1'b0, 1'b1, 1'b0);
        check(dout == 1'b1, "R8 cell kept", dout, 1);

        // R9: phase overlap
        precharge();
        @(negedge clk);
        pre_ph = 1'b1; acc_ph = 1'b1;
        @(negedge clk);
        pre_ph = 1'b0; acc_ph = 1'b0;
        primed = 1'b0;
        @(negedge clk);
        check(err_proto == 1'b1, "R9 err_proto", err_proto, 1);
        check(bl_ready == 1'b0, "R9 precharge lost", bl_ready, 0);

        // random interleaved traffic against the reference array
        void'($urandom(32'h1c3a));
        for (int n = 0; n < 400; n++) begin
            logic [6:0] a;
            int         kind;
            a    = 7'($urandom % CELLS);
            kind = int'($urandom % 10);
            if (kind < 5)       op(a, 1'b0, 1'b1, 1'b0);
            else if (kind < 9)  op(a, 1'($urandom), 1'b0, 1'b1);
            else                op(a, 1'($urandom), 1'b1, 1'b1);
        end

        // R2 sweep of every cell
        for (int k = 0; k < CELLS; k++) begin
            op(7'(k), 1'b0, 1'b1, 1'b0);
            check(dout == ref_mem[k], "R2 sweep", dout, ref_mem[k]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule